// File: doc/BRIEF.md
# NAND Flash Bus Strobe Sequencer

This block connects a simple host request port to an 8-bit asynchronous NAND flash bus. Each host request is one byte transfer: a read or a write, marked as a command, an address or a data byte. For every transfer the block pulls chip enable low and raises the matching latch-enable line. It then produces one write-enable or read-enable pulse. The pulse passes through a setup phase, a strobe phase and a hold phase, and the length of each phase is programmable. A turnaround gap with chip enable high follows every transfer.

All timing comes from one 32-bit configuration word. Reads and writes have separate setup, strobe and hold counts, and the word also holds a turnaround count. The host writes the word and can read it back. The flash ready/busy pin passes through a two-flop synchronizer and appears in bit 0 of a status byte.

A request is accepted only while the block is idle. The block latches the timing in force at that moment, so a configuration write made mid-transfer takes effect from the next accepted request.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: After reset, chip enable, write enable and read enable are high (inactive), CLE, ALE, busy and read-valid are low, and the configuration word reads 0x0432229C. This value is write setup 1, write strobe 3, write hold 1, read setup 1, read strobe 5, read hold 1, turnaround 3 and width code 0.
- R2: The configuration word reads back exactly as last written, including the reserved bits [31:30] and the width code [1:0]. The timing fields are:
  - read hold [6:4]
  - turnaround [3:2]
  - write setup [29:26]
  - read strobe [12:7]
  - write strobe [25:20]
  - read setup [16:13]
  - write hold [19:17]
- R3: Chip enable is low for setup, strobe and hold. Before the strobe pin goes low, chip enable is low for (setup field + 1) cycles. The strobe pin is then low for (strobe field + 1) cycles. After the strobe rises, chip enable stays low for (hold field + 1) cycles. Writes use the write fields and reads use the read fields.
- R4: Request kind code 1 (command) drives CLE=1 and ALE=0, and code 2 (address) drives ALE=1 and CLE=0. Codes 0 and 3 are data transfers and drive both lines low. CLE and ALE are both low whenever chip enable is high.
- R5: A write pulses only write enable and never read enable. From the first setup cycle to the last hold cycle, the data output enable is high and the data bus carries the request byte unchanged.
- R6: A read pulses only read enable and keeps the data output enable low. The byte on the data input during the last strobe cycle is captured. Read-valid is then high for exactly one cycle, in the first hold cycle, and the read data holds the captured byte.
- R7: After hold, chip enable is high for (turnaround field + 1) cycles while busy stays high.
- R8: Busy rises in the cycle after acceptance and falls after the last turnaround cycle. A transfer therefore lasts (setup+strobe+hold+turnaround+4) busy cycles. Requests presented while busy is high are ignored: the transfer in progress keeps its byte and kind, and no transfer follows it.
- R9: Status bit 0 follows the ready/busy pin (1 = ready) after a two-flop synchronizer. Status bits [7:1] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word to store |
| cfg_rdata | output | 32 | Stored configuration word |
| req_valid | input | 1 | Transfer request, taken only when not busy |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_kind | input | 2 | 0 data, 1 command, 2 address, 3 data |
| req_wdata | input | 8 | Byte to write |
| busy | output | 1 | Transfer in progress, including turnaround |
| rd_data | output | 8 | Last captured read byte |
| rd_valid | output | 1 | One-cycle pulse when a read byte is captured |
| status | output | 8 | Bit 0 synchronized ready flag, others zero |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write enable strobe, active low |
| nand_re_n | output | 1 | Read enable strobe, active low |
| nand_dq_out | output | 8 | Data bus value driven toward the flash |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_dq_in | input | 8 | Data bus value from the flash |
| nand_rb_n | input | 1 | Flash ready/busy pin, 1 = ready |

## Verification
The bench sweeps every phase field through zero and small non-zero values. It gives the read fields values that differ from the write fields. This exposes a design that loses the "+1" on a zero field or swaps the read and write counts: the bench measures each phase length at the pins, and either fault changes a measured length. The bench changes the data input on every strobe cycle, so a design that captures one cycle early or late returns the wrong byte. It also holds a second request with a different byte while busy is high. A design that accepts that request either changes the byte on the bus or starts a second transfer after the first. The bench also checks the latch lines for all four kind codes and reads back reserved configuration bits.

// File: rtl/nand_strobe_pkg.sv
package nand_strobe_pkg;

  localparam int CFG_W  = 32;
  localparam int SU_W   = 4;
  localparam int ST_W   = 6;
  localparam int HD_W   = 3;
  localparam int TA_W   = 2;
  localparam int CNT_W  = ST_W;

  // field positions of the packed configuration word
  localparam int WSU_LSB = 26;
  localparam int WST_LSB = 20;
  localparam int WHD_LSB = 17;
  localparam int RSU_LSB = 13;
  localparam int RST_LSB = 7;
  localparam int RHD_LSB = 4;
  localparam int TA_LSB  = 2;

  localparam logic [CFG_W-1:0] CFG_RESET = 32'h0432_229C;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_TURN   = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    KIND_DATA = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_ADDR = 2'd2,
    KIND_ALT  = 2'd3
  } kind_e;

  typedef struct packed {
    logic [SU_W-1:0] setup;
    logic [ST_W-1:0] strobe;
    logic [HD_W-1:0] hold;
  } dir_timing_t;

endpackage

// File: rtl/nand_cfg_reg.sv
module nand_cfg_reg
  import nand_strobe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output dir_timing_t      wr_t,
  output dir_timing_t      rd_t,
  output logic [TA_W-1:0]  turn
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (we) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end

  always_comb begin
    rdata     = cfg_q;
    wr_t.setup  = cfg_q[WSU_LSB +: SU_W];
    wr_t.strobe = cfg_q[WST_LSB +: ST_W];
    wr_t.hold   = cfg_q[WHD_LSB +: HD_W];
    rd_t.setup  = cfg_q[RSU_LSB +: SU_W];
    rd_t.strobe = cfg_q[RST_LSB +: ST_W];
    rd_t.hold   = cfg_q[RHD_LSB +: HD_W];
    turn        = cfg_q[TA_LSB +: TA_W];
  end

  // R2: a written word is returned whole, reserved bits included
  a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rdata == $past(wdata)));

endmodule

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign sync_out = sh_q[STAGES-1];

endmodule

// File: rtl/nand_phase_seq.sv
module nand_phase_seq
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_wdata,
  input  dir_timing_t       wr_t,
  input  dir_timing_t       rd_t,
  input  logic [TA_W-1:0]   turn,
  input  logic [DATA_W-1:0] dq_in,
  output phase_e            phase,
  output logic              busy,
  output logic              op_write,
  output logic [1:0]        op_kind,
  output logic [DATA_W-1:0] op_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  phase_e            phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  dir_timing_t       tim_q;
  logic [TA_W-1:0]   turn_q;
  logic              wr_q;
  logic [1:0]        kind_q;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rdat_q;
  logic              rvld_q;
  logic              load;
  logic              cap;
  logic              cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  // next-state: each phase is loaded with its field and counts down to zero
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    load    = 1'b0;
    cap     = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req_valid) begin
          phase_d = PH_SETUP;
          load    = 1'b1;
          cnt_d   = req_write ? CNT_W'(wr_t.setup) : CNT_W'(rd_t.setup);
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_STROBE;
          cnt_d   = CNT_W'(tim_q.strobe);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_STROBE: begin
        if (cnt_zero) begin
          phase_d = PH_HOLD;
          cnt_d   = CNT_W'(tim_q.hold);
          cap     = !wr_q;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (cnt_zero) begin
          phase_d = PH_TURN;
          cnt_d   = CNT_W'(turn_q);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_TURN: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      rvld_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      rvld_q  <= cap;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q  <= '0;
      turn_q <= '0;
      wr_q   <= 1'b0;
      kind_q <= KIND_DATA;
      data_q <= '0;
    end else if (load) begin
      tim_q  <= req_write ? wr_t : rd_t;
      turn_q <= turn;
      wr_q   <= req_write;
      kind_q <= req_kind;
      data_q <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rdat_q <= '0;
    else if (cap) rdat_q <= dq_in;
  end

  assign phase    = phase_q;
  assign busy     = (phase_q != PH_IDLE);
  assign op_write = wr_q;
  assign op_kind  = kind_q;
  assign op_data  = data_q;
  assign rd_data  = rdat_q;
  assign rd_valid = rvld_q;

  // R8: a transfer always begins with the setup phase
  a_r8_start_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (phase_q == PH_SETUP));

  // R8: requests seen while busy leave the latched transfer untouched
  a_r8_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(op_data) && $stable(op_kind) && $stable(op_write)));

  // R6: a capture pulse only follows the final strobe cycle of a read
  a_r6_capture_slot: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((phase_q == PH_HOLD) && !wr_q && $past(phase_q == PH_STROBE)));

  // R7: turnaround is always followed by idle or more turnaround
  a_r7_turn_exit: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_TURN) |=> (phase_q inside {PH_TURN, PH_IDLE}));

endmodule

// File: rtl/nand_pin_drive.sv
module nand_pin_drive
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  phase_e            phase,
  input  logic              op_write,
  input  logic [1:0]        op_kind,
  input  logic [DATA_W-1:0] op_data,
  output logic              ce_n,
  output logic              cle,
  output logic              ale,
  output logic              we_n,
  output logic              re_n,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  logic active;
  logic strobing;

  always_comb begin
    active   = (phase == PH_SETUP) || (phase == PH_STROBE) || (phase == PH_HOLD);
    strobing = (phase == PH_STROBE);
    ce_n     = !active;
    cle      = active && (op_kind == KIND_CMD);
    ale      = active && (op_kind == KIND_ADDR);
    we_n     = !(strobing && op_write);
    re_n     = !(strobing && !op_write);
    dq_oe    = active && op_write;
    dq_out   = op_data;
  end

  // R4: never both latch enables at once
  a_r4_latch_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));

  // R5: at most one strobe low, and only under chip enable
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> (!ce_n && (we_n != re_n)));

  // R5: driven write data does not change during the transfer
  a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out));

endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
  import nand_strobe_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RB_SYNC  = 2,
  parameter int STAT_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [1:0]        req_kind,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              busy,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [STAT_W-1:0] status,
  output logic              nand_ce_n,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic              nand_we_n,
  output logic              nand_re_n,
  output logic [DATA_W-1:0] nand_dq_out,
  output logic              nand_dq_oe,
  input  logic [DATA_W-1:0] nand_dq_in,
  input  logic              nand_rb_n
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sh_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sh_q <= 2'b00;
    else        rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_int_n = rst_sh_q[1];

  dir_timing_t       wr_t, rd_t;
  logic [TA_W-1:0]   turn;
  phase_e            phase;
  logic              op_write;
  logic [1:0]        op_kind;
  logic [DATA_W-1:0] op_data;
  logic              rb_sync;

  nand_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_int_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .wr_t  (wr_t),
    .rd_t  (rd_t),
    .turn  (turn)
  );

  nand_phase_seq #(.DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_kind  (req_kind),
    .req_wdata (req_wdata),
    .wr_t      (wr_t),
    .rd_t      (rd_t),
    .turn      (turn),
    .dq_in     (nand_dq_in),
    .phase     (phase),
    .busy      (busy),
    .op_write  (op_write),
    .op_kind   (op_kind),
    .op_data   (op_data),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid)
  );

  nand_pin_drive #(.DATA_W(DATA_W)) u_pins (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .phase    (phase),
    .op_write (op_write),
    .op_kind  (op_kind),
    .op_data  (op_data),
    .ce_n     (nand_ce_n),
    .cle      (nand_cle),
    .ale      (nand_ale),
    .we_n     (nand_we_n),
    .re_n     (nand_re_n),
    .dq_out   (nand_dq_out),
    .dq_oe    (nand_dq_oe)
  );

  nand_rb_sync #(.STAGES(RB_SYNC)) u_rb (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .async_in (nand_rb_n),
    .sync_out (rb_sync)
  );

  assign status = {{(STAT_W-1){1'b0}}, rb_sync};

  // R9: the upper status bits carry nothing
  a_r9_status_upper: assert property (@(posedge clk) disable iff (!rst_int_n)
    (status[STAT_W-1:1] == '0));

endmodule

// File: tb/nand_strobe_ctrl_tb.sv
module nand_strobe_ctrl_tb;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [31:0] cfg_wdata;
  logic [31:0] cfg_rdata;
  logic        req_valid;
  logic        req_write;
  logic [1:0]  req_kind;
  logic [7:0]  req_wdata;
  logic        busy;
  logic [7:0]  rd_data;
  logic        rd_valid;
  logic [7:0]  status;
  logic        nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n;
  logic [7:0]  nand_dq_out;
  logic        nand_dq_oe;
  logic [7:0]  nand_dq_in;
  logic        nand_rb_n;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  nand_strobe_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_write(req_write), .req_kind(req_kind),
    .req_wdata(req_wdata), .busy(busy), .rd_data(rd_data), .rd_valid(rd_valid),
    .status(status), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb_n(nand_rb_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(int ws, int wt, int wh, int rs, int rt, int rh, int ta);
    return (32'(ws) << 26) | (32'(wt) << 20) | (32'(wh) << 17) |
           (32'(rs) << 13) | (32'(rt) << 7) | (32'(rh) << 4) | (32'(ta) << 2);
  endfunction

  task automatic write_cfg(input logic [31:0] w);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // one transfer, measured at the pins on falling edges
  task automatic access(input bit wr, input int kind, input logic [7:0] dat,
                        input int s, input int t, input int h, input int ta,
                        input bit poke);
    int n_pre = 0, n_str = 0, n_post = 0, n_ta = 0, n_rv = 0, n_busy = 0;
    int bad_lat = 0, bad_dir = 0;
    bit seen_str = 0;
    logic [7:0] pat;
    pat = dat ^ 8'h5A;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_kind = 2'(kind); req_wdata = dat;
    for (int it = 0; it < 400; it++) begin
      @(negedge clk);
      if (poke && it < 2) begin
        req_valid = 1'b1; req_write = !wr; req_kind = 2'(kind ^ 1); req_wdata = ~dat;
      end else begin
        req_valid = 1'b0;
      end
      if (!busy) break;
      n_busy++;
      if (rd_valid) n_rv++;
      if (!nand_ce_n) begin
        if (nand_cle != (kind == 1) || nand_ale != (kind == 2)) bad_lat++;
        if (!nand_we_n || !nand_re_n) begin
          seen_str = 1;
          n_str++;
          if (wr && !(nand_re_n && !nand_we_n)) bad_dir++;
          if (!wr && !(nand_we_n && !nand_re_n)) bad_dir++;
          if (!wr) nand_dq_in = pat ^ 8'(n_str);
        end else if (!seen_str) n_pre++;
        else n_post++;
        if (wr && !(nand_dq_oe && nand_dq_out == dat)) bad_dir++;
        if (!wr && nand_dq_oe) bad_dir++;
      end else begin
        n_ta++;
        if (nand_cle || nand_ale || !nand_we_n || !nand_re_n || nand_dq_oe) bad_lat++;
      end
    end
    chk(n_pre == s + 1, "R3 setup cycles", n_pre, s + 1);
    chk(n_str == t + 1, "R3 strobe cycles", n_str, t + 1);
    chk(n_post == h + 1, "R3 hold cycles", n_post, h + 1);
    chk(n_ta == ta + 1, "R7 turnaround cycles", n_ta, ta + 1);
    chk(n_busy == s + t + h + ta + 4, "R8 busy length", n_busy, s + t + h + ta + 4);
    chk(bad_lat == 0, "R4 latch lines", bad_lat, 0);
    if (wr) begin
      chk(bad_dir == 0, "R5 write strobe/data", bad_dir, 0);
      chk(n_rv == 0, "R5 no read-valid on write", n_rv, 0);
    end else begin
      chk(bad_dir == 0, "R6 read strobe/oe", bad_dir, 0);
      chk(n_rv == 1, "R6 read-valid pulses", n_rv, 1);
      chk(rd_data == (pat ^ 8'(t + 1)), "R6 captured byte", rd_data, pat ^ 8'(t + 1));
    end
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!busy && nand_ce_n, "R8 ignored request", {busy, nand_ce_n}, 1);
      end
    end
  endtask

  initial begin
    int tv[3];
    tv[0] = 0; tv[1] = 1; tv[2] = 3;
    rst_n = 1'b0; cfg_we = 0; cfg_wdata = 0; req_valid = 0; req_write = 0;
    req_kind = 0; req_wdata = 0; nand_dq_in = 0; nand_rb_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(nand_ce_n && nand_we_n && nand_re_n, "R1 strobes idle", {nand_ce_n, nand_we_n, nand_re_n}, 7);
    chk(!nand_cle && !nand_ale && !busy && !rd_valid, "R1 lines low",
        {nand_cle, nand_ale, busy, rd_valid}, 0);
    chk(cfg_rdata == 32'h0432229C, "R1 config reset", cfg_rdata, 32'h0432229C);

    // R9 ready/busy synchronizer
    chk(status == 8'h00, "R9 busy flash", status, 0);
    @(negedge clk); nand_rb_n = 1'b1;
    @(negedge clk);
    chk(status[0] == 1'b0, "R9 two-flop delay", status, 0);
    @(negedge clk);
    chk(status == 8'h01, "R9 ready flash", status, 1);

    // typical reset timing, both directions
    access(1, 1, 8'h70, 1, 3, 1, 3, 0);
    access(0, 0, 8'h00, 1, 5, 1, 3, 0);

    // R2 full readback, reserved bits and width code
    write_cfg(32'hC000_0003 | mk_cfg(5, 9, 2, 7, 11, 6, 1));
    chk(cfg_rdata == (32'hC000_0003 | mk_cfg(5, 9, 2, 7, 11, 6, 1)), "R2 readback",
        cfg_rdata, 32'hC000_0003 | mk_cfg(5, 9, 2, 7, 11, 6, 1));
    write_cfg(32'h8000_0000 | mk_cfg(2, 1, 0, 0, 2, 1, 1));
    chk(cfg_rdata[31:30] == 2'b10, "R2 reserved bits", cfg_rdata[31:30], 2);
    access(1, 2, 8'hA5, 2, 1, 0, 1, 0);
    access(0, 2, 8'h3C, 0, 2, 1, 1, 0);

    // sweep of small timing values, read fields differ from write fields
    for (int s = 0; s < 3; s++)
      for (int ti = 0; ti < 3; ti++)
        for (int h = 0; h < 2; h++)
          for (int ta = 0; ta < 3; ta++) begin
            int rs, rt, rh;
            rs = 2 - s; rt = tv[2 - ti]; rh = 1 - h;
            write_cfg(mk_cfg(s, tv[ti], h, rs, rt, rh, ta));
            access(1, 0, 8'(s * 16 + ti * 4 + ta), s, tv[ti], h, ta, 0);
            access(1, 1, 8'h90 ^ 8'(h), s, tv[ti], h, ta, 1);
            access(1, 2, 8'hE1, s, tv[ti], h, ta, 0);
            access(0, 0, 8'h17 ^ 8'(ta), rs, rt, rh, ta, 0);
            access(0, 3, 8'hC3, rs, rt, rh, ta, 0);
          end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule